// File: doc/BRIEF.md
# Ping-Pong DMA Channel

This block is a single DMA channel that moves data in fixed-length bursts from two alternating memory buffers. Software programs a start address and a burst count for each of buffer A and buffer B, then sets a start flag for each buffer. While the channel is enabled, a sequencer serves the buffer named by a buffer-select flag. It issues one request per burst on a request/acknowledge memory port and advances its pointer by the burst size after each acknowledge. When the count runs out, it marks that buffer done and flips to the other buffer. Software refills one buffer while the other is being transferred.

The enable bit can pause the channel at any time and resume it later. A burst that is already under way always finishes, and a resumed channel continues from the pointer it had reached. If a burst would start at an address inside a reserved window, the channel flags an error instead and stays halted until software clears the flag. One interrupt line reports completions and errors. A single ready input stands in for peripheral pacing. A device address register is held for the peripheral side.

Top module: `pingpong_dma_chan`

## Requirements

The register map is as follows. Offset 0 is control. Offset 1 is the device address. Offsets 2 and 3 are the buffer A base and count. Offsets 4 and 5 are the buffer B base and count. Offset 6 is the current pointer, which is read-only. The control word has these bits:

| Bit | Name | Behaviour |
|---|---|---|
| 0 | run | Read/write |
| 1 | irq enable | Read/write |
| 2 | start A | Writing 1 sets it; writing 0 has no effect |
| 3 | start B | Writing 1 sets it; writing 0 has no effect |
| 4 | done A | Write 1 to clear |
| 5 | done B | Write 1 to clear |
| 6 | error | Write 1 to clear |
| 7 | buffer select | Read-only; 0 means A, 1 means B |

- R1: After reset, every register reads 0, and mem_req and irq are low.
- R2: A buffer with count N>0 produces N bursts, at base, base+BURST_BYTES, and so on. Each mem_req stays high with a stable mem_addr until mem_ack is seen.
- R3: When the last burst of a buffer is acknowledged, three things happen on the same edge: the done bit of that buffer sets, its start bit clears, and buffer select toggles. The other buffer is then served if its start bit is set. Only reset clears buffer select.
- R4: When both start bits are set, the buffer named by buffer select is served first.
- R5: Clearing run during a burst lets that burst complete, and no new burst begins. Setting run again resumes at the current pointer in the same buffer.
- R6: irq is high exactly when irq enable is set and at least one of done A, done B and error is set. Clearing these bits by writing 1 to them lowers irq.
- R7: A write to the device address register is ignored while run is 1.
- R8: A write to a buffer's base or count register is ignored while that buffer's start bit is 1.
- R9: A burst whose address lies in [RSV_LO, RSV_HI] is not issued; error sets instead. While error is set, no burst is issued.
- R10: The channel idles while the selected buffer's start bit is 0, even with run set. When run and the selected buffer's start bit are already set, the first mem_req is high in the cycle after the start write.
- R11: A buffer whose count is 0 completes at once, with no memory request. It then takes the R3 completion actions.
- R12: No burst begins while dev_ready is low.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Read data for reg_addr (combinational) |
| dev_ready | input | 1 | Peripheral can accept another burst |
| mem_req | output | 1 | Burst request |
| mem_addr | output | AW | Burst start address |
| mem_ack | input | 1 | Burst accepted |
| dev_addr | output | AW | Device address register contents |
| irq | output | 1 | Channel interrupt |

## Verification

The bench builds the channel with CW=8, BURST_BYTES=16 and a reserved window from 0xE0000000 to 0xEFFFFFFF. Small counts keep each buffer down to a few bursts, so a single run can cover a double-buffer hand-off, a pause in mid-buffer, a zero-count buffer and a return to buffer A. The window sits far above the test buffers. This way a single base write puts a buffer into the error case without disturbing the others.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] RA_DEV    = 3'd1;
  localparam logic [REG_AW-1:0] RA_BASE_A = 3'd2;
  localparam logic [REG_AW-1:0] RA_CNT_A  = 3'd3;
  localparam logic [REG_AW-1:0] RA_BASE_B = 3'd4;
  localparam logic [REG_AW-1:0] RA_CNT_B  = 3'd5;
  localparam logic [REG_AW-1:0] RA_PTR    = 3'd6;

  localparam int CB_RUN = 0;
  localparam int CB_IEN = 1;
  localparam int CB_STA = 2;
  localparam int CB_DNA = 4;
  localparam int CB_ERR = 6;
  localparam int CB_SEL = 7;

  typedef enum logic {SQ_IDLE = 1'b0, SQ_BURST = 1'b1} sq_state_e;
endpackage

// File: rtl/pp_dma_window.sv
module pp_dma_window #(
  parameter int AW = 32,
  parameter logic [AW-1:0] LO = 32'hE000_0000,
  parameter logic [AW-1:0] HI = 32'hEFFF_FFFF
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  assign hit = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
  import pp_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [AW-1:0]     wdata,
  output logic [AW-1:0]     rdata,
  input  logic              seq_done,
  input  logic              seq_err,
  input  logic [AW-1:0]     ptr,
  output logic              run,
  output logic              err,
  output logic              buf_sel,
  output logic [1:0]        start,
  output logic [AW-1:0]     base_a,
  output logic [AW-1:0]     base_b,
  output logic [CW-1:0]     cnt_a,
  output logic [CW-1:0]     cnt_b,
  output logic [AW-1:0]     dev_addr,
  output logic              irq
);
  logic          run_q, run_n, ien_q, ien_n, err_q, err_n, sel_q, sel_n, irq_q, irq_n;
  logic [1:0]    start_q, start_n, done_q, done_n;
  logic [AW-1:0] dev_q, dev_n;
  logic [AW-1:0] base_q [2];
  logic [AW-1:0] base_n [2];
  logic [CW-1:0] cnt_q  [2];
  logic [CW-1:0] cnt_n  [2];
  logic          wr_ctrl;

  assign wr_ctrl = wr && (addr == RA_CTRL);

  always_comb begin
    run_n = wr_ctrl ? wdata[CB_RUN] : run_q;
    ien_n = wr_ctrl ? wdata[CB_IEN] : ien_q;
    err_n = (err_q & ~(wr_ctrl & wdata[CB_ERR])) | seq_err;
    sel_n = sel_q ^ seq_done;
    dev_n = (wr && (addr == RA_DEV) && !run_q) ? wdata : dev_q;
    for (int b = 0; b < 2; b++) begin
      start_n[b] = (start_q[b] & ~(seq_done && (sel_q == b[0])))
                 | (wr_ctrl & wdata[CB_STA+b]);
      done_n[b]  = (done_q[b] & ~(wr_ctrl & wdata[CB_DNA+b]))
                 | (seq_done && (sel_q == b[0]));
      base_n[b]  = (wr && (addr == (b[0] ? RA_BASE_B : RA_BASE_A)) && !start_q[b])
                 ? wdata : base_q[b];
      cnt_n[b]   = (wr && (addr == (b[0] ? RA_CNT_B : RA_CNT_A)) && !start_q[b])
                 ? wdata[CW-1:0] : cnt_q[b];
    end
    irq_n = ien_n & ((|done_n) | err_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ien_q   <= 1'b0;
      err_q   <= 1'b0;
      sel_q   <= 1'b0;
      irq_q   <= 1'b0;
      start_q <= '0;
      done_q  <= '0;
      dev_q   <= '0;
      for (int b = 0; b < 2; b++) begin
        base_q[b] <= '0;
        cnt_q[b]  <= '0;
      end
    end else begin
      run_q   <= run_n;
      ien_q   <= ien_n;
      err_q   <= err_n;
      sel_q   <= sel_n;
      irq_q   <= irq_n;
      start_q <= start_n;
      done_q  <= done_n;
      dev_q   <= dev_n;
      for (int b = 0; b < 2; b++) begin
        base_q[b] <= base_n[b];
        cnt_q[b]  <= cnt_n[b];
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      RA_CTRL: begin
        rdata[CB_RUN]           = run_q;
        rdata[CB_IEN]           = ien_q;
        rdata[CB_STA+1:CB_STA]  = start_q;
        rdata[CB_DNA+1:CB_DNA]  = done_q;
        rdata[CB_ERR]           = err_q;
        rdata[CB_SEL]           = sel_q;
      end
      RA_DEV:    rdata = dev_q;
      RA_BASE_A: rdata = base_q[0];
      RA_CNT_A:  rdata = AW'(cnt_q[0]);
      RA_BASE_B: rdata = base_q[1];
      RA_CNT_B:  rdata = AW'(cnt_q[1]);
      RA_PTR:    rdata = ptr;
      default:   rdata = '0;
    endcase
  end

  assign run      = run_q;
  assign err      = err_q;
  assign buf_sel  = sel_q;
  assign start    = start_q;
  assign base_a   = base_q[0];
  assign base_b   = base_q[1];
  assign cnt_a    = cnt_q[0];
  assign cnt_b    = cnt_q[1];
  assign dev_addr = dev_q;
  assign irq      = irq_q;
endmodule

// File: rtl/pp_dma_seq.sv
module pp_dma_seq
  import pp_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int BURST_BYTES = 16,
  parameter logic [AW-1:0] RSV_LO = 32'hE000_0000,
  parameter logic [AW-1:0] RSV_HI = 32'hEFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          err,
  input  logic          buf_sel,
  input  logic [1:0]    start,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  input  logic          dev_ready,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic [AW-1:0] ptr,
  output logic          seq_done,
  output logic          seq_err
);
  localparam logic [AW-1:0] STEP = AW'(BURST_BYTES);

  sq_state_e     st_q, st_n;
  logic [AW-1:0] ptr_q, ptr_n, eff_ptr;
  logic [CW-1:0] rem_q, rem_n, eff_rem;
  logic          act_q, act_n, go, in_rsv;

  pp_dma_window #(.AW(AW), .LO(RSV_LO), .HI(RSV_HI)) u_win (
    .addr(eff_ptr),
    .hit (in_rsv)
  );

  always_comb begin
    go       = run & ~err & start[buf_sel];
    eff_ptr  = act_q ? ptr_q : (buf_sel ? base_b : base_a);
    eff_rem  = act_q ? rem_q : (buf_sel ? cnt_b : cnt_a);
    st_n     = st_q;
    ptr_n    = ptr_q;
    rem_n    = rem_q;
    act_n    = act_q;
    seq_done = 1'b0;
    seq_err  = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (go) begin
          if (eff_rem == '0) begin
            seq_done = 1'b1;
            act_n    = 1'b0;
          end else if (dev_ready) begin
            ptr_n = eff_ptr;
            rem_n = eff_rem;
            act_n = 1'b1;
            if (in_rsv) seq_err = 1'b1;
            else        st_n    = SQ_BURST;
          end
        end
      end
      SQ_BURST: begin
        if (mem_ack) begin
          ptr_n = ptr_q + STEP;
          rem_n = rem_q - CW'(1);
          st_n  = SQ_IDLE;
          if (rem_q == CW'(1)) begin
            seq_done = 1'b1;
            act_n    = 1'b0;
          end
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      ptr_q <= '0;
      rem_q <= '0;
      act_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      ptr_q <= ptr_n;
      rem_q <= rem_n;
      act_q <= act_n;
    end
  end

  assign mem_req = (st_q == SQ_BURST);
  assign ptr     = ptr_q;
endmodule

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan
  import pp_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int BURST_BYTES = 16,
  parameter logic [AW-1:0] RSV_LO = 32'hE000_0000,
  parameter logic [AW-1:0] RSV_HI = 32'hEFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [AW-1:0]     reg_wdata,
  output logic [AW-1:0]     reg_rdata,
  input  logic              dev_ready,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ack,
  output logic [AW-1:0]     dev_addr,
  output logic              irq
);
  logic          run_w, err_w, sel_w, done_w, serr_w;
  logic [1:0]    start_w;
  logic [AW-1:0] base_a_w, base_b_w, ptr_w;
  logic [CW-1:0] cnt_a_w, cnt_b_w;

  pp_dma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .seq_done(done_w),
    .seq_err (serr_w),
    .ptr     (ptr_w),
    .run     (run_w),
    .err     (err_w),
    .buf_sel (sel_w),
    .start   (start_w),
    .base_a  (base_a_w),
    .base_b  (base_b_w),
    .cnt_a   (cnt_a_w),
    .cnt_b   (cnt_b_w),
    .dev_addr(dev_addr),
    .irq     (irq)
  );

  pp_dma_seq #(
    .AW(AW), .CW(CW), .BURST_BYTES(BURST_BYTES), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .err      (err_w),
    .buf_sel  (sel_w),
    .start    (start_w),
    .base_a   (base_a_w),
    .base_b   (base_b_w),
    .cnt_a    (cnt_a_w),
    .cnt_b    (cnt_b_w),
    .dev_ready(dev_ready),
    .mem_ack  (mem_ack),
    .mem_req  (mem_req),
    .ptr      (ptr_w),
    .seq_done (done_w),
    .seq_err  (serr_w)
  );

  assign mem_addr = ptr_w;
endmodule

// File: rtl/pp_dma_chk.sv
module pp_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          dev_ready,
  input logic          run,
  input logic          err,
  input logic          buf_sel,
  input logic          seq_done
);
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req);

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(mem_addr));

  a_r3_sel_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(buf_sel) |-> $past(seq_done));

  a_r5_burst_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(run));

  a_r9_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !mem_req) |=> !mem_req);

  a_r12_burst_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(dev_ready));
endmodule

bind pingpong_dma_chan pp_dma_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .dev_ready(dev_ready),
  .run      (run_w),
  .err      (err_w),
  .buf_sel  (sel_w),
  .seq_done (done_w)
);

// File: tb/pingpong_dma_chan_bench.sv
module pingpong_dma_chan_bench;
  localparam int AW = 32;
  localparam int CW = 8;
  localparam int NV = 14;

  logic          clk, rst_n, reg_wr, dev_ready, mem_ack, mem_req, irq;
  logic [2:0]    reg_addr;
  logic [AW-1:0] reg_wdata, reg_rdata, mem_addr, dev_addr;
  int            errors, checks;

  pingpong_dma_chan #(.AW(AW), .CW(CW), .BURST_BYTES(16),
    .RSV_LO(32'hE000_0000), .RSV_HI(32'hEFFF_FFFF)) u_pingpong_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_ready(dev_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .dev_addr(dev_addr), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {write, offset, data, expected read}
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 3'd1, 32'h4000_0100, 32'h0},
    {1'b0, 3'd1, 32'h0, 32'h4000_0100},
    {1'b1, 3'd2, 32'h0000_1000, 32'h0},
    {1'b0, 3'd2, 32'h0, 32'h0000_1000},
    {1'b1, 3'd3, 32'h3, 32'h0},
    {1'b0, 3'd3, 32'h0, 32'h3},
    {1'b1, 3'd4, 32'h0000_2000, 32'h0},
    {1'b0, 3'd4, 32'h0, 32'h0000_2000},
    {1'b1, 3'd5, 32'h2, 32'h0},
    {1'b1, 3'd0, 32'h1, 32'h0},
    {1'b1, 3'd1, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 3'd1, 32'h0, 32'h4000_0100},
    {1'b1, 3'd0, 32'h0, 32'h0},
    {1'b0, 3'd0, 32'h0, 32'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  task automatic quiet(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mem_req !== 1'b0) hits++;
    end
    chk(hits == 0, req, 32'(hits), 32'h0);
  endtask

  task automatic wait_req();
    for (int i = 0; i < 50 && mem_req !== 1'b1; i++) @(negedge clk);
  endtask

  task automatic serve(input logic [31:0] exp, input string req);
    wait_req();
    chk(mem_req === 1'b1 && mem_addr === exp, req, mem_addr, exp);
    @(negedge clk);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors = 0; checks = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    dev_ready = 1'b1; mem_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, 32'h0, "R1 ctrl");
    rd(3'd2, 32'h0, "R1 base A");
    rd(3'd6, 32'h0, "R1 pointer");
    chk(mem_req === 1'b0 && irq === 1'b0, "R1 outputs", {30'b0, mem_req, irq}, 32'h0);

    // register vectors; R7 device address gated by run
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][67]) wr(VEC[v][66:64], VEC[v][63:32]);
      else rd(VEC[v][66:64], VEC[v][31:0], $sformatf("R7 R8 vector %0d", v));
    end

    // R8 base and count frozen while start A set
    wr(3'd0, 32'h4);
    wr(3'd2, 32'h9999);
    rd(3'd2, 32'h1000, "R8 base A frozen");
    wr(3'd3, 32'h7);
    rd(3'd3, 32'h3, "R8 count A frozen");

    // R10 first request one cycle after start; R4 A first; R2 sequence
    wr(3'd0, 32'hF);
    @(negedge clk);
    chk(mem_req === 1'b1, "R10 prompt start", {31'b0, mem_req}, 32'h1);
    serve(32'h1000, "R4 buffer A first");
    serve(32'h1010, "R2 second burst");
    serve(32'h1020, "R2 third burst");
    rd(3'd0, 32'h9B, "R3 done A, start A clear, select B");
    chk(irq === 1'b1, "R6 irq on done", {31'b0, irq}, 32'h1);

    // R5 pause in mid-burst, then resume
    wait_req();
    chk(mem_addr === 32'h2000, "R3 buffer B follows", mem_addr, 32'h2000);
    wr(3'd0, 32'h2);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    chk(mem_req === 1'b0, "R5 burst finished", {31'b0, mem_req}, 32'h0);
    quiet(10, "R5 paused");
    rd(3'd6, 32'h2010, "R5 pointer kept");
    wr(3'd0, 32'h3);
    serve(32'h2010, "R5 resumed");
    rd(3'd0, 32'h33, "R3 both done, select back to A");

    // R6 write-1-to-clear
    wr(3'd0, 32'h13);
    chk(irq === 1'b1, "R6 irq held by done B", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h23);
    chk(irq === 1'b0, "R6 irq cleared", {31'b0, irq}, 32'h0);

    // R11 zero count
    wr(3'd3, 32'h0);
    wr(3'd2, 32'h3000);
    wr(3'd0, 32'h7);
    quiet(8, "R11 no request");
    rd(3'd0, 32'h93, "R11 done A, select B");
    wr(3'd0, 32'h13);

    // R10 idle while selected start clear; R12 ready gating
    wr(3'd3, 32'h1);
    wr(3'd0, 32'h7);
    quiet(10, "R10 selected B not started");
    rd(3'd0, 32'h87, "R10 start A pending");
    dev_ready = 1'b0;
    wr(3'd0, 32'hB);
    quiet(10, "R12 not ready");
    dev_ready = 1'b1;
    serve(32'h2000, "R12 after ready");
    serve(32'h2010, "R2 buffer B second");
    serve(32'h3000, "R3 A after B");
    rd(3'd0, 32'hB3, "R3 both done, select B");

    // R9 reserved window
    wr(3'd0, 32'h73);
    wr(3'd4, 32'hE000_0040);
    wr(3'd5, 32'h1);
    wr(3'd0, 32'hB);
    quiet(10, "R9 no request");
    rd(3'd0, 32'hCB, "R9 error set");
    chk(irq === 1'b1, "R6 irq on error", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h0);
    chk(irq === 1'b0, "R6 irq masked", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h40);
    rd(3'd0, 32'h88, "R9 error cleared");
    wr(3'd0, 32'h1);
    quiet(6, "R9 halted again");
    rd(3'd0, 32'hC9, "R9 error again");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule